// File: doc/BRIEF.md
# Boot Mode Latch and Remapper

This block decides which memory the processor starts from. Two boot-select inputs are sampled on a counted clock edge after reset is released. They are sampled again, with the same delay, whenever the device leaves standby. The sampled pair is decoded into a 2-bit boot-mode code, and that code drives the alias of the code region at address zero. The secondary select input shares its pad with a general-purpose pin, so once sampling is over a release output hands that pin back.

Control is a two-state machine. `ST_COUNT` counts clock edges until the capture edge. `ST_RUN` holds the latched mode, permits instruction fetch and releases the shared pin. Its transitions are:

- **T_CAPTURE**: `ST_COUNT` to `ST_RUN`, on the capture edge.
- **T_WAKE**: `ST_RUN` to `ST_COUNT`, on a standby-exit request. The count is cleared.
- **T_RESTART**: `ST_COUNT` to `ST_COUNT`, when a standby-exit request arrives during a count. The count starts again from zero.

A combinational remap port takes a fetch or data address and returns the physical memory select together with the offset inside that memory.

Top module: `boot_remap_top`

## Requirements
- R1: While reset is asserted and just after it, `mode_o` is 00 and `fetch_en_o`, `pin_release_o` and `sample_done_o` are all 0.
- R2: The select inputs are captured on the 4th rising clock edge after reset deasserts. `fetch_en_o` stays 0 before that edge. `sample_done_o` is 1 for exactly the one cycle that follows it, and the inputs seen on earlier edges have no effect.
- R3: When the primary select is 0, `mode_o` becomes 00 (main flash), whatever the secondary select is.
- R4: When the primary select is 1 and the secondary is 0, `mode_o` becomes 01 (system memory).
- R5: When both selects are 1, `mode_o` becomes 11 (embedded SRAM). The code 10 never appears on `mode_o`.
- R6: Once captured, `mode_o` does not change when the select inputs change, until the next reset or standby exit.
- R7: A standby-exit request sampled on a clock edge drops `fetch_en_o` and `pin_release_o` after that edge. The selects are then captured again on the 4th edge after the request edge.
- R8: A standby-exit request that arrives while a count is running restarts the count from zero.
- R9: `pin_release_o` and `fetch_en_o` are 1 from the cycle after capture until the next standby exit or reset.
- R10: An address whose top three bits are 000 (code region) gives `hit_o`=1 and `tgt_o`=`mode_o`, so both address 0x0000_0000 and address 0x0000_0004 resolve to the boot memory.
- R11: An address whose top three bits are 001 (data region at 0x2000_0000) gives `hit_o`=1 and `tgt_o`=11 (SRAM) in every boot mode.
- R12: Any other address gives `hit_o`=0 and `tgt_o`=00. `off_o` is always the address with its top three bits removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_exit_i | input | 1 | Request, sampled on a clock edge, to recapture after standby |
| sel_pri_i | input | 1 | Primary boot-select input (dedicated pin) |
| sel_sec_i | input | 1 | Secondary boot-select input (shared pin) |
| mode_o | output | 2 | Latched boot mode: 00 flash, 01 system memory, 11 SRAM |
| sample_done_o | output | 1 | One-cycle strobe after each capture |
| pin_release_o | output | 1 | Shared select pin is free for general-purpose use |
| fetch_en_o | output | 1 | Instruction fetch permitted |
| addr_i | input | 32 | Address to remap |
| hit_o | output | 1 | Address lies in the code or data region |
| tgt_o | output | 2 | Physical memory select, same coding as `mode_o` |
| off_o | output | 29 | Offset inside the selected memory |

## Verification
The assertions assume three things about the inputs. `standby_exit_i` is a synchronous request that changes only between clock edges. Reset is applied from time zero. The select inputs are settled before the capture edge. The bench meets these by changing every input on the falling edge and by holding reset low from the first instant. It also pulses the standby request for exactly one rising edge per event, except in the restart scenario, which deliberately places a second pulse inside a running count.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        MODE_FLASH = 2'b00,
        MODE_SYS   = 2'b01,
        MODE_SRAM  = 2'b11
    } boot_mode_e;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_RUN   = 1'b1
    } seq_state_e;

    function automatic boot_mode_e decode_sel(input logic pri, input logic sec);
        if (!pri)     return MODE_FLASH;
        else if (sec) return MODE_SRAM;
        else          return MODE_SYS;
    endfunction

endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm #(
    parameter int SAMPLE_EDGE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    output logic capture_o,
    output logic done_o,
    output logic run_o
);
    import boot_pkg::*;

    localparam int CW = $clog2(SAMPLE_EDGE + 1);
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_EDGE - 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           done_q;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        capture_o = 1'b0;
        if (wake_i) begin
            state_d = ST_COUNT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (cnt_q == LAST) begin
                        capture_o = 1'b1;
                        state_d   = ST_RUN;
                        cnt_d     = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    state_d = ST_RUN;
                end
                default: state_d = ST_COUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= capture_o;
        end
    end

    // outputs
    always_comb begin
        run_o  = (state_q == ST_RUN);
        done_o = done_q;
    end

endmodule

// File: rtl/boot_mode_reg.sv
module boot_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_i,
    input  logic       pri_i,
    input  logic       sec_i,
    output logic [1:0] mode_o
);
    import boot_pkg::*;

    boot_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mode_q <= MODE_FLASH;
        else if (capture_i) mode_q <= decode_sel(pri_i, sec_i);
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/boot_addr_remap.sv
module boot_addr_remap #(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 3
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [1:0]                    mode_i,
    output logic                          hit_o,
    output logic [1:0]                    tgt_o,
    output logic [ADDR_W-REGION_BITS-1:0] off_o
);
    import boot_pkg::*;

    localparam logic [REGION_BITS-1:0] CODE_RGN = '0;
    localparam logic [REGION_BITS-1:0] DATA_RGN = REGION_BITS'(1);

    logic [REGION_BITS-1:0] rgn;

    always_comb begin
        rgn   = addr_i[ADDR_W-1 -: REGION_BITS];
        off_o = addr_i[ADDR_W-REGION_BITS-1:0];
        hit_o = 1'b0;
        tgt_o = 2'b00;
        if (rgn == CODE_RGN) begin
            hit_o = 1'b1;
            tgt_o = mode_i;
        end else if (rgn == DATA_RGN) begin
            hit_o = 1'b1;
            tgt_o = MODE_SRAM;
        end
    end

endmodule

// File: rtl/boot_remap_top.sv
module boot_remap_top #(
    parameter int SAMPLE_EDGE = 4,
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          standby_exit_i,
    input  logic                          sel_pri_i,
    input  logic                          sel_sec_i,
    output logic [1:0]                    mode_o,
    output logic                          sample_done_o,
    output logic                          pin_release_o,
    output logic                          fetch_en_o,
    input  logic [ADDR_W-1:0]             addr_i,
    output logic                          hit_o,
    output logic [1:0]                    tgt_o,
    output logic [ADDR_W-REGION_BITS-1:0] off_o
);
    logic capture;
    logic run;

    boot_seq_fsm #(.SAMPLE_EDGE(SAMPLE_EDGE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_i    (standby_exit_i),
        .capture_o (capture),
        .done_o    (sample_done_o),
        .run_o     (run)
    );

    boot_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .pri_i     (sel_pri_i),
        .sec_i     (sel_sec_i),
        .mode_o    (mode_o)
    );

    boot_addr_remap #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_remap (
        .addr_i (addr_i),
        .mode_i (mode_o),
        .hit_o  (hit_o),
        .tgt_o  (tgt_o),
        .off_o  (off_o)
    );

    assign fetch_en_o    = run;
    assign pin_release_o = run;

endmodule

// File: rtl/boot_remap_chk.sv
module boot_remap_chk #(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          standby_exit_i,
    input logic [1:0]                    mode_o,
    input logic                          sample_done_o,
    input logic                          pin_release_o,
    input logic                          fetch_en_o,
    input logic [ADDR_W-1:0]             addr_i,
    input logic                          hit_o,
    input logic [1:0]                    tgt_o
);
    logic [REGION_BITS-1:0] rgn;
    assign rgn = addr_i[ADDR_W-1 -: REGION_BITS];

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_done_o |=> !sample_done_o);

    p_fetch_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_en_o) |-> sample_done_o);

    p_no_unused_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b10);

    p_mode_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> sample_done_o);

    p_wake_blocks_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        standby_exit_i |=> (!fetch_en_o && !pin_release_o));

    p_release_with_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en_o == pin_release_o);

    p_code_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == '0) |-> (hit_o && tgt_o == mode_o));

    p_data_sram_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == REGION_BITS'(1)) |-> (hit_o && tgt_o == 2'b11));

endmodule

bind boot_remap_top boot_remap_chk #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .standby_exit_i (standby_exit_i),
    .mode_o         (mode_o),
    .sample_done_o  (sample_done_o),
    .pin_release_o  (pin_release_o),
    .fetch_en_o     (fetch_en_o),
    .addr_i         (addr_i),
    .hit_o          (hit_o),
    .tgt_o          (tgt_o)
);

// File: tb/tb_boot_remap_top.sv
`timescale 1ns/1ps
module tb_boot_remap_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sx = 1'b0;
    logic        pri = 1'b0;
    logic        sec = 1'b0;
    logic [31:0] addr = 32'h0;
    logic [1:0]  mode;
    logic        done, rel, fen, hit;
    logic [1:0]  tgt;
    logic [28:0] off;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    boot_remap_top dut (
        .clk(clk), .rst_n(rst_n), .standby_exit_i(sx),
        .sel_pri_i(pri), .sel_sec_i(sec),
        .mode_o(mode), .sample_done_o(done), .pin_release_o(rel),
        .fetch_en_o(fen), .addr_i(addr), .hit_o(hit), .tgt_o(tgt), .off_o(off)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected mode for a pin pair
    function automatic logic [1:0] exp_mode(input logic p, input logic s);
        return !p ? 2'b00 : (s ? 2'b11 : 2'b01);
    endfunction

    task automatic t_reset_capture(input logic p, input logic s, input string rq);
        rst_n = 1'b0; pri = p; sec = s;
        step(2);
        chk("R1 mode in reset", mode, 2'b00);
        chk("R1 fetch in reset", fen, 0);
        chk("R1 release in reset", rel, 0);
        chk("R1 done in reset", done, 0);
        rst_n = 1'b1;
        step(3);
        chk("R2 fetch before 4th edge", fen, 0);
        chk("R2 done before 4th edge", done, 0);
        chk("R9 release before capture", rel, 0);
        step(1);
        chk("R2 done after 4th edge", done, 1);
        chk("R9 fetch after capture", fen, 1);
        chk("R9 release after capture", rel, 1);
        chk(rq, mode, exp_mode(p, s));
        step(1);
        chk("R2 done one cycle", done, 0);
    endtask

    task automatic t_late_change;
        rst_n = 1'b0; pri = 1'b0; sec = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(2);
        pri = 1'b1; sec = 1'b1;
        step(2);
        chk("R2 value at 4th edge used", mode, 2'b11);
    endtask

    task automatic t_ignore_pins;
        pri = 1'b0; sec = 1'b0;
        step(5);
        chk("R6 mode held", mode, 2'b11);
        chk("R6 no strobe", done, 0);
        pri = 1'b1; sec = 1'b0;
        step(3);
        chk("R6 mode held again", mode, 2'b11);
    endtask

    task automatic t_standby(input logic p, input logic s);
        pri = p; sec = s;
        sx = 1'b1;
        step(1);
        sx = 1'b0;
        chk("R7 fetch drops", fen, 0);
        chk("R7 release drops", rel, 0);
        step(3);
        chk("R7 still counting", fen, 0);
        step(1);
        chk("R7 recapture strobe", done, 1);
        chk("R7 recaptured mode", mode, exp_mode(p, s));
        chk("R7 fetch back", fen, 1);
    endtask

    task automatic t_restart;
        pri = 1'b1; sec = 1'b0;
        sx = 1'b1; step(1); sx = 1'b0;
        step(2);
        sx = 1'b1; step(1); sx = 1'b0;
        step(3);
        chk("R8 count restarted", fen, 0);
        chk("R8 no early strobe", done, 0);
        step(1);
        chk("R8 capture after restart", done, 1);
        chk("R8 mode", mode, 2'b01);
    endtask

    task automatic t_remap(input logic [1:0] m);
        addr = 32'h0000_0000; #0.5;
        chk("R10 top-of-stack hit", hit, 1);
        chk("R10 top-of-stack target", tgt, m);
        addr = 32'h0000_0004; #0.5;
        chk("R10 reset vector target", tgt, m);
        chk("R12 offset", off, 29'h4);
        addr = 32'h2000_0300; #0.5;
        chk("R11 data hit", hit, 1);
        chk("R11 data sram", tgt, 2'b11);
        chk("R12 data offset", off, 29'h300);
        addr = 32'h4001_0000; #0.5;
        chk("R12 other miss", hit, 0);
        chk("R12 other target", tgt, 2'b00);
        addr = 32'h0;
    endtask

    initial begin
        t_reset_capture(1'b0, 1'b1, "R3 flash with sec=1");
        t_remap(2'b00);
        t_reset_capture(1'b0, 1'b0, "R3 flash with sec=0");
        t_reset_capture(1'b1, 1'b0, "R4 system memory");
        t_remap(2'b01);
        t_reset_capture(1'b1, 1'b1, "R5 sram");
        t_remap(2'b11);
        t_late_change;
        t_ignore_pins;
        t_standby(1'b1, 1'b0);
        t_standby(1'b0, 1'b1);
        t_remap(2'b00);
        t_restart;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule